// File: doc/BRIEF.md
# Nonvolatile Configuration Status Register

This block keeps the device configuration byte: a two-bit watchdog period select and a three-bit block-protect field, with the remaining upper bits reserved and always reading as zero. A serial command decoder drives it with single-cycle strobes: one to set the write-enable latch, one to write a new status byte, and one to request a status read. The read byte appears one cycle after the request.

An accepted write does not reach the configuration outputs at once. It starts an external write-cycle timer (`cyc_start`) and stays pending until the timer answers with `cyc_done`. While that cycle runs, status reads return only a busy flag in the top bit. The first read after the cycle ends returns a cleared top bit with every other bit zero. Later reads return the committed contents. Finishing the cycle also clears the write-enable latch.

Top module: `nvstat_reg`

## Requirements
- R1: After reset, `wd_sel` is 2'b11, `bl_sel` is 3'b000, `wel` and `busy` are 0, and a status read returns 8'h18.
- R2: When idle, a read returns the byte {3'b000, wd_sel, bl_sel}: the watchdog select in bits 4:3, the block-protect field in bits 2:0, and zero in bits 7:5. The byte is valid on `rd_byte` the cycle after `rd_stb`.
- R3: A `wel_set` strobe sets `wel` when the block is idle. A write strobe while `wel` is 0 is ignored: `cyc_start` stays low and the contents do not change.
- R4: A write whose data has any of bits 7:5 set is ignored. `cyc_start` stays low, the contents do not change, and `wel` stays set.
- R5: An accepted write raises `cyc_start` in the same cycle as the strobe, and `busy` is 1 from the next cycle.
- R6: While `busy` is 1, every read returns 8'h80, however many reads there are.
- R7: While `busy` is 1, write strobes and `wel_set` strobes have no effect.
- R8: `wd_sel` and `bl_sel` keep their old values through the write cycle. They take the written bits 4:3 and 2:0 at the edge where `cyc_done` is seen while busy.
- R9: `cyc_done` while busy clears both `busy` and `wel` at the next edge.
- R10: The first read after a cycle completes returns 8'h00. The reads after it return the committed contents.
- R11: `cyc_done` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wel_set | input | 1 | Strobe that sets the write-enable latch |
| wr_stb | input | 1 | Status write strobe |
| wr_data | input | 8 | Status byte to write |
| rd_stb | input | 1 | Status read request |
| rd_byte | output | 8 | Status read result, valid the cycle after `rd_stb` |
| cyc_start | output | 1 | Starts the write-cycle timer |
| cyc_done | input | 1 | Write-cycle timer finished |
| busy | output | 1 | Write cycle in progress |
| wel | output | 1 | Write-enable latch |
| wd_sel | output | 2 | Committed watchdog period select |
| bl_sel | output | 3 | Committed block-protect field |

## Verification
The assertions assume that every strobe lasts one cycle and that `cyc_done` arrives as a single pulse, some cycles after `cyc_start`. The bench models the timer this way, with a short fixed delay. It sends `cyc_done` while idle only in the R11 case, which the assertions tolerate because they constrain `cyc_done` only while `busy` is high. Every input changes on the falling edge, so each strobe is seen by exactly one rising edge.

// File: rtl/nvstat_pkg.sv
package nvstat_pkg;
  localparam int STAT_W = 8;
  localparam int WD_W   = 2;
  localparam int BL_W   = 3;
  localparam int CFG_W  = WD_W + BL_W;
  localparam int RSV_W  = STAT_W - CFG_W;
  localparam int FLAG_BIT = STAT_W - 1;

  typedef struct packed {
    logic [WD_W-1:0] wd;
    logic [BL_W-1:0] bl;
  } cfg_t;

  localparam logic [STAT_W-1:0] BUSY_WORD = STAT_W'(1) << FLAG_BIT;
  localparam logic [STAT_W-1:0] DONE_WORD = '0;

  function automatic logic [STAT_W-1:0] pack_status(cfg_t c);
    return {{RSV_W{1'b0}}, c};
  endfunction

  function automatic logic reserved_clear(logic [STAT_W-1:0] d);
    return d[STAT_W-1 -: RSV_W] == '0;
  endfunction

  function automatic cfg_t unpack_cfg(logic [STAT_W-1:0] d);
    return cfg_t'(d[CFG_W-1:0]);
  endfunction
endpackage

// File: rtl/nvstat_wel.sv
module nvstat_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic busy,
  input  logic clr_evt,
  output logic wel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wel <= 1'b0;
    else if (clr_evt)         wel <= 1'b0;
    else if (set_req && !busy) wel <= 1'b1;
  end
endmodule

// File: rtl/nvstat_cycle.sv
module nvstat_cycle (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done_in,
  input  logic post_read,
  output logic busy,
  output logic done_evt,
  output logic post_done
);
  assign done_evt = busy && done_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      post_done <= 1'b0;
    end else begin
      if (start)         busy <= 1'b1;
      else if (done_evt) busy <= 1'b0;
      if (done_evt)       post_done <= 1'b1;
      else if (post_read) post_done <= 1'b0;
    end
  end
endmodule

// File: rtl/nvstat_readout.sv
module nvstat_readout
  import nvstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              busy,
  input  logic              post_done,
  input  cfg_t              cfg,
  output logic [STAT_W-1:0] rd_byte
);
  logic [STAT_W-1:0] next_byte;

  always_comb begin
    if (busy)           next_byte = BUSY_WORD;
    else if (post_done) next_byte = DONE_WORD;
    else                next_byte = pack_status(cfg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_byte <= '0;
    else if (rd_stb) rd_byte <= next_byte;
  end
endmodule

// File: rtl/nvstat_reg.sv
module nvstat_reg
  import nvstat_pkg::*;
#(
  parameter logic [1:0] RST_WD = 2'b11,
  parameter logic [2:0] RST_BL = 3'b000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wel_set,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       rd_stb,
  output logic [7:0] rd_byte,
  output logic       cyc_start,
  input  logic       cyc_done,
  output logic       busy,
  output logic       wel,
  output logic [1:0] wd_sel,
  output logic [2:0] bl_sel
);
  cfg_t cfg_q, pend_q;
  logic wr_go, done_evt, post_done, post_read;

  assign wr_go     = wr_stb && wel && !busy && reserved_clear(wr_data);
  assign cyc_start = wr_go;
  assign post_read = rd_stb && !busy && post_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= cfg_t'({RST_WD, RST_BL});
      pend_q <= cfg_t'({RST_WD, RST_BL});
    end else begin
      if (wr_go)    pend_q <= unpack_cfg(wr_data);
      if (done_evt) cfg_q  <= pend_q;
    end
  end

  assign wd_sel = cfg_q.wd;
  assign bl_sel = cfg_q.bl;

  nvstat_wel u_wel (
    .clk(clk), .rst_n(rst_n), .set_req(wel_set), .busy(busy),
    .clr_evt(done_evt), .wel(wel)
  );

  nvstat_cycle u_cyc (
    .clk(clk), .rst_n(rst_n), .start(wr_go), .done_in(cyc_done),
    .post_read(post_read), .busy(busy), .done_evt(done_evt),
    .post_done(post_done)
  );

  nvstat_readout u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .busy(busy),
    .post_done(post_done), .cfg(cfg_q), .rd_byte(rd_byte)
  );
endmodule

// File: rtl/nvstat_reg_chk.sv
module nvstat_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wel_set,
  input logic       wr_stb,
  input logic [7:0] wr_data,
  input logic       rd_stb,
  input logic [7:0] rd_byte,
  input logic       cyc_start,
  input logic       cyc_done,
  input logic       busy,
  input logic       wel,
  input logic [1:0] wd_sel,
  input logic [2:0] bl_sel
);
  p_start_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> wel);
  p_start_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> wr_data[7:5] == 3'b000);
  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> busy);
  p_busy_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_stb) |=> rd_byte == 8'h80);
  p_no_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cyc_start);
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && cyc_done) |=> ($stable(wd_sel) && $stable(bl_sel)));
  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc_done) |=> (!busy && !wel));
  p_reserved_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !busy) |=> rd_byte[7:5] == 3'b000);
endmodule

bind nvstat_reg nvstat_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wr_stb(wr_stb),
  .wr_data(wr_data), .rd_stb(rd_stb), .rd_byte(rd_byte),
  .cyc_start(cyc_start), .cyc_done(cyc_done), .busy(busy), .wel(wel),
  .wd_sel(wd_sel), .bl_sel(bl_sel)
);

// File: tb/nvstat_reg_test.sv
`timescale 1ns/1ps
module nvstat_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wel_set = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, cyc_done = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_byte;
  logic cyc_start, busy, wel;
  logic [1:0] wd_sel;
  logic [2:0] bl_sel;

  int tests = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  nvstat_reg uut (
    .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_byte(rd_byte),
    .cyc_start(cyc_start), .cyc_done(cyc_done), .busy(busy), .wel(wel),
    .wd_sel(wd_sel), .bl_sel(bl_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_wel();
    @(negedge clk); wel_set = 1'b1;
    @(negedge clk); wel_set = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d, output bit started);
    @(negedge clk); wr_stb = 1'b1; wr_data = d;
    #1 started = cyc_start;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    v = rd_byte;
  endtask

  task automatic timer_done();
    @(negedge clk); cyc_done = 1'b1;
    @(negedge clk); cyc_done = 1'b0;
  endtask

  function automatic logic [7:0] contents(input logic [7:0] d);
    return d % 8'd32;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] cur, v;
    bit st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wd_sel == 2'b11 && bl_sel == 3'b000, "R1", {wd_sel, bl_sel}, 5'h18);
    chk(!wel && !busy, "R1", {wel, busy}, 0);
    do_read(v);
    chk(v == 8'h18, "R1", v, 8'h18);
    cur = 8'h18;

    for (int d = 0; d < 256; d++) begin
      logic [7:0] dd;
      dd = 8'(d);
      pulse_wel();
      chk(wel, "R3", wel, 1);
      do_write(dd, st);
      if (dd / 32 != 0) begin
        chk(!st, "R4", st, 0);
        do_read(v);
        chk(v == cur, "R4", v, cur);
        chk(wel, "R4", wel, 1);
      end else begin
        chk(st, "R5", st, 1);
        chk(busy, "R5", busy, 1);
        do_read(v);
        chk(v == 8'h80, "R6", v, 8'h80);
        do_read(v);
        chk(v == 8'h80, "R6", v, 8'h80);
        chk({wd_sel, bl_sel} == cur[4:0], "R8", {wd_sel, bl_sel}, cur[4:0]);
        do_write(dd ^ 8'h1f, st);
        chk(!st, "R7", st, 0);
        repeat (2) @(negedge clk);
        timer_done();
        chk(!busy && !wel, "R9", {busy, wel}, 0);
        cur = contents(dd);
        chk(wd_sel == cur[4:3] && bl_sel == cur[2:0], "R8", {wd_sel, bl_sel}, cur[4:0]);
        do_read(v);
        chk(v == 8'h00, "R10", v, 0);
        do_read(v);
        chk(v == cur, "R10", v, cur);
        chk(v[7:5] == 3'b000 && v[4:3] == dd[4:3] && v[2:0] == dd[2:0], "R2", v, cur);
      end
    end

    // R4 left wel set; finish one legal cycle to clear it
    do_write(8'h09, st);
    timer_done();
    do_read(v); do_read(v);
    cur = 8'h09;
    chk(v == cur, "R2", v, cur);

    // R3: write with latch clear
    do_write(8'h16, st);
    chk(!st, "R3", st, 0);
    do_read(v);
    chk(v == cur, "R3", v, cur);

    // R11: done while idle
    timer_done();
    chk(!busy, "R11", busy, 0);
    do_read(v);
    chk(v == cur, "R11", v, cur);

    // R7: wel_set during busy has no effect on the cleared latch
    pulse_wel();
    do_write(8'h12, st);
    pulse_wel();
    timer_done();
    chk(!wel, "R7", wel, 0);
    do_write(8'h05, st);
    chk(!st, "R7", st, 0);

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule